// File: doc/BRIEF.md
# Dual-Clock FIFO with SECDED Word Protection

This block is a first-in first-out buffer that carries 64-bit words between two unrelated clock domains. Each word is encoded on entry with eight check bits that correct one flipped bit and detect two. The 72-bit result is held in an internal array. On exit the word is decoded, repaired when possible, and presented together with its check byte and two error indicators. Write and read locations come from internal counters. The counters move between domains as Gray code through two-stage synchronizers, and one extra wrap bit tells full apart from empty.

The writer sees full and almost-full. The reader sees empty and almost-empty. A refused request on either side raises a one-cycle error pulse in that side's clock. Two inject inputs corrupt a word while it is stored, so that the correction and detection paths can be exercised. The data output and the error indicators come from a register that only a read updates. For this reason reset leaves them as they were.

Top module: `ecc_async_fifo`

## Requirements
- R1: While reset is held and after it is released, empty=1, almost_empty=1, full=0, almost_full=0, both error pulses are 0 and both counts are 0.
- R2: Words leave in the order they were accepted. With no injection, rd_data equals the written word, err_single=0 and err_double=0. rd_parity follows this rule. Number the codeword positions 1..71 and hand the non-powers of two, in ascending order, to data bits 0..63. Check bit k (k=0..6) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R3: The decoded outputs change in the read-clock cycle that follows an accepted read. They then hold until the next accepted read.
- R4: After 2^ADDR_W (default 512) accepted writes with no reads, full=1. A write attempted while full is not stored and does not move wr_count. It raises wr_overflow for exactly the following write-clock cycle.
- R5: A read attempted while empty does not move rd_count and does not change rd_data. It raises rd_underflow for the following read-clock cycle.
- R6: almost_full=1 when the write-side fill is at least 2^ADDR_W-AFULL_GAP (default 508). almost_empty=1 when the read-side fill is at most AEMPTY_GAP (default 4).
- R7: inj_single=1 during a write flips stored data bit 30. Reading that word returns the original data and check byte, with err_single=1 and err_double=0.
- R8: inj_double=1 during a write, alone or together with inj_single, flips stored data bits 30 and 62. Reading that word returns the corrupted word and its stored check byte, with err_double=1 and err_single=0.
- R9: wr_count and rd_count are the (ADDR_W+1)-bit binary counts of accepted writes and reads since reset, wrapping at 2^(ADDR_W+1).
- R10: Asserting rst_n low, for at least three cycles of each clock, clears the counts and flags. It leaves rd_data, rd_parity, err_single and err_double unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 64 | Word to store |
| inj_single | input | 1 | Corrupt one stored bit of this write |
| inj_double | input | 1 | Corrupt two stored bits of this write |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Decoded word |
| rd_parity | output | 8 | Check byte of the decoded word |
| err_single | output | 1 | Single-bit error was corrected |
| err_double | output | 1 | Double-bit error detected, not corrected |
| full | output | 1 | No free entry (write side) |
| almost_full | output | 1 | Fill at or above high threshold (write side) |
| empty | output | 1 | No stored entry (read side) |
| almost_empty | output | 1 | Fill at or below low threshold (read side) |
| wr_overflow | output | 1 | Pulse: write refused while full |
| rd_underflow | output | 1 | Pulse: read refused while empty |
| wr_count | output | ADDR_W+1 | Write pointer count |
| rd_count | output | ADDR_W+1 | Read pointer count |

## Verification
The hardest situation to reach is the upper boundary. The write pointer must sit a full wrap ahead of the synchronized read pointer, and the almost-full edge must be observed one entry at a time. The stimulus first moves both pointers off zero with a short write/read exchange. It then writes 512 patterned words without reading, checks the almost-full edge at fills 507 and 508, and pushes once more into the full array. Afterwards it drains every word in order and checks the almost-empty edge on the way down. The inject cases and the reset-hold case follow on the same non-zero pointers.

// File: rtl/fifo_ecc_pkg.sv
package fifo_ecc_pkg;
  localparam int DW = 64;
  localparam int PW = 8;
  localparam int CW = DW + PW;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [PW-1:0] par;
    logic          sbe;
    logic          dbe;
  } ecc_rd_t;

  // check byte: positions 1..71, non-powers of two carry data in order
  function automatic logic [PW-1:0] ecc_gen(input logic [DW-1:0] d);
    logic [PW-1:0] p;
    int n;
    p = '0;
    n = 0;
    for (int pos = 1; pos < CW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int k = 0; k < PW - 1; k++)
          if (pos[k]) p[k] = p[k] ^ d[n];
        n = n + 1;
      end
    end
    p[PW-1] = ^{d, p[PW-2:0]};
    return p;
  endfunction

  function automatic ecc_rd_t ecc_check(input logic [CW-1:0] w);
    ecc_rd_t r;
    logic [DW-1:0] d;
    logic [PW-1:0] g;
    logic [PW-2:0] syn;
    logic          odd;
    int n;
    d   = w[DW-1:0];
    g   = ecc_gen(d);
    syn = g[PW-2:0] ^ w[CW-2:DW];
    odd = ^w;
    n   = 0;
    if (odd) begin
      for (int pos = 1; pos < CW; pos++) begin
        if ((pos & (pos - 1)) != 0) begin
          if (pos == int'(syn)) d[n] = ~d[n];
          n = n + 1;
        end
      end
    end
    r.sbe  = odd;
    r.dbe  = !odd && (syn != '0);
    r.data = r.dbe ? w[DW-1:0] : d;
    r.par  = r.dbe ? w[CW-1:DW] : ecc_gen(d);
    return r;
  endfunction
endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
  parameter int AW    = 9,
  parameter int GAP   = 4,
  parameter bit IS_WR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [AW:0] far_gray,
  output logic [AW:0] bin,
  output logic [AW:0] gray,
  output logic        flag,
  output logic        near,
  output logic        err,
  output logic        acc
);
  localparam int DEPTH = 1 << AW;

  logic [AW:0] bin_nx, gray_nx, far_bin, fill;
  logic        err_nx;

  always_comb begin
    for (int i = AW; i >= 0; i--)
      far_bin[i] = (i == AW) ? far_gray[i] : far_bin[i+1] ^ far_gray[i];
  end

  generate
    if (IS_WR) begin : g_wr
      assign flag = (gray == {~far_gray[AW:AW-1], far_gray[AW-2:0]});
      assign fill = bin - far_bin;
      assign near = (fill >= (AW+1)'(DEPTH - GAP));
    end else begin : g_rd
      assign flag = (gray == far_gray);
      assign fill = far_bin - bin;
      assign near = (fill <= (AW+1)'(GAP));
    end
  endgenerate

  always_comb begin
    acc     = req && !flag;
    bin_nx  = bin + (AW+1)'(acc);
    gray_nx = (bin_nx >> 1) ^ bin_nx;
    err_nx  = req && flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
      err  <= 1'b0;
    end else begin
      bin  <= bin_nx;
      gray <= gray_nx;
      err  <= err_nx;
    end
  end

  generate
    if (IS_WR) begin : g_wr_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req && flag) |=> (bin == $past(bin)));  // R4
      AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req && flag));  // R4
    end else begin : g_rd_chk
      AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req && flag) |=> (bin == $past(bin)));  // R5
      AST_UDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req && flag));  // R5
    end
  endgenerate

  AST_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1);  // R2
endmodule

// File: rtl/ecc_async_fifo.sv
module ecc_async_fifo
  import fifo_ecc_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int AFULL_GAP  = 4,
  parameter int AEMPTY_GAP = 4
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  input  logic              inj_single,
  input  logic              inj_double,
  input  logic              rd_en,
  output logic [63:0]       rd_data,
  output logic [7:0]        rd_parity,
  output logic              err_single,
  output logic              err_double,
  output logic              full,
  output logic              almost_full,
  output logic              empty,
  output logic              almost_empty,
  output logic              wr_overflow,
  output logic              rd_underflow,
  output logic [ADDR_W:0]   wr_count,
  output logic [ADDR_W:0]   rd_count
);
  localparam int DEPTH = 1 << ADDR_W;

  logic            wrst_n, rrst_n;
  logic [ADDR_W:0] wgray, rgray, wgray_s, rgray_s;
  logic            w_acc, r_acc;
  logic [DW-1:0]   inj_mask;
  logic [CW-1:0]   mem [DEPTH];
  logic [CW-1:0]   rword;
  ecc_rd_t         dec;

  fifo_sync2 #(.W(1)) i_wrst (.clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wrst_n));
  fifo_sync2 #(.W(1)) i_rrst (.clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rrst_n));

  fifo_sync2 #(.W(ADDR_W+1)) i_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  fifo_sync2 #(.W(ADDR_W+1)) i_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  fifo_ptr #(.AW(ADDR_W), .GAP(AFULL_GAP), .IS_WR(1'b1)) i_wptr (
    .clk(wr_clk), .rst_n(wrst_n), .req(wr_en), .far_gray(rgray_s),
    .bin(wr_count), .gray(wgray), .flag(full), .near(almost_full),
    .err(wr_overflow), .acc(w_acc));

  fifo_ptr #(.AW(ADDR_W), .GAP(AEMPTY_GAP), .IS_WR(1'b0)) i_rptr (
    .clk(rd_clk), .rst_n(rrst_n), .req(rd_en), .far_gray(wgray_s),
    .bin(rd_count), .gray(rgray), .flag(empty), .near(almost_empty),
    .err(rd_underflow), .acc(r_acc));

  always_comb begin
    inj_mask     = '0;
    inj_mask[30] = inj_single || inj_double;
    inj_mask[62] = inj_double;
  end

  always_ff @(posedge wr_clk) begin
    if (w_acc) mem[wr_count[ADDR_W-1:0]] <= {ecc_gen(wr_data), wr_data ^ inj_mask};
  end

  always_ff @(posedge rd_clk) begin
    if (r_acc) rword <= mem[rd_count[ADDR_W-1:0]];
  end

  always_comb begin
    dec        = ecc_check(rword);
    rd_data    = dec.data;
    rd_parity  = dec.par;
    err_single = dec.sbe;
    err_double = dec.dbe;
  end

  AST_ONE_ERR_KIND: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    $past(r_acc) |-> !(err_single && err_double));  // R7
  AST_HOLD_DATA: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    !$past(r_acc) |-> $stable(rword));  // R3
endmodule

// File: tb/test_ecc_async_fifo.sv
module test_ecc_async_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = (CLK_PERIOD * 7) / 5;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en = 0, inj_single = 0, inj_double = 0, rd_en = 0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [7:0] rd_parity;
  logic err_single, err_double, full, almost_full, empty, almost_empty;
  logic wr_overflow, rd_underflow;
  logic [AW:0] wr_count, rd_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RCLK_PERIOD/2) rd_clk = ~rd_clk;

  ecc_async_fifo #(.ADDR_W(AW), .AFULL_GAP(4), .AEMPTY_GAP(4)) i_ecc_async_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .inj_single(inj_single), .inj_double(inj_double),
    .rd_en(rd_en), .rd_data(rd_data), .rd_parity(rd_parity),
    .err_single(err_single), .err_double(err_double), .full(full),
    .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty),
    .wr_overflow(wr_overflow), .rd_underflow(rd_underflow),
    .wr_count(wr_count), .rd_count(rd_count));

  // expected check byte, from the coding rule stated in R2
  function automatic logic [7:0] exp_par(input logic [63:0] d);
    logic [7:0] p;
    int pos;
    p = '0;
    pos = 1;
    for (int i = 0; i < 64; i++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < 7; k++) if ((pos >> k) & 1) p[k] ^= d[i];
      pos++;
    end
    p[7] = ^d ^ ^p[6:0];
    return p;
  endfunction

  function automatic logic [63:0] pat(input int i);
    return {32'hA5A50000 + i, 32'(i) * 32'h01000193};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge rd_clk);
    repeat (5) @(posedge wr_clk);
  endtask

  task automatic push(input logic [63:0] d, input bit s, input bit dd);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d; inj_single = s; inj_double = dd;
    @(negedge wr_clk);
    wr_en = 0; inj_single = 0; inj_double = 0;
  endtask

  task automatic pop_check(input logic [63:0] d, input logic [7:0] p,
                           input bit sb, input bit db, input string req);
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    check(rd_data === d, req, "rd_data", rd_data, d);
    check(rd_parity === p, req, "rd_parity", {56'd0, rd_parity}, {56'd0, p});
    check(err_single === sb && err_double === db, req, "err flags",
          {62'd0, err_single, err_double}, {62'd0, sb, db});
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk);
    check(empty && almost_empty && !full && !almost_full, "R1", "flags in reset",
          {60'd0, empty, almost_empty, full, almost_full}, 64'hC);
    rst_n = 1;
    settle();
    @(negedge wr_clk);
    check(!full && !almost_full && !wr_overflow && wr_count == 0, "R1", "write side",
          {wr_count, full, almost_full, wr_overflow}, 64'd0);
    @(negedge rd_clk);
    check(empty && almost_empty && !rd_underflow && rd_count == 0, "R1", "read side",
          {rd_count, empty, almost_empty, rd_underflow}, 64'd6);
  endtask

  task automatic t_order();
    logic [63:0] v [5];
    v[0] = 64'h0; v[1] = '1; v[2] = 64'h0123_4567_89AB_CDEF;
    v[3] = 64'h8000_0000_0000_0001; v[4] = 64'h5555_AAAA_3C3C_C3C3;
    for (int i = 0; i < 5; i++) push(v[i], 0, 0);
    settle();
    for (int i = 0; i < 5; i++) pop_check(v[i], exp_par(v[i]), 0, 0, "R2");
    repeat (3) @(negedge rd_clk);
    check(rd_data === v[4], "R3", "hold without read", rd_data, v[4]);
    check(wr_count == 5 && rd_count == 5, "R9", "counts after 5",
          {wr_count, rd_count}, {10'd5, 10'd5});
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < DEPTH; i++) begin
      push(pat(i), 0, 0);
      if (i == DEPTH - 6) check(!almost_full, "R6", "almost_full at 507", 64'(almost_full), 0);
      if (i == DEPTH - 5) check(almost_full, "R6", "almost_full at 508", 64'(almost_full), 1);
      if (i == DEPTH - 2) check(!full, "R4", "full at 511", 64'(full), 0);
    end
    check(full, "R4", "full at 512", 64'(full), 1);
    @(negedge wr_clk);
    wr_en = 1; wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
    @(negedge wr_clk);
    wr_en = 0;
    check(wr_overflow, "R4", "overflow pulse", 64'(wr_overflow), 1);
    check(wr_count == 10'd517, "R9", "wr_count unchanged", 64'(wr_count), 517);
    @(negedge wr_clk);
    check(!wr_overflow, "R4", "overflow single cycle", 64'(wr_overflow), 0);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge rd_clk);
      if (i == DEPTH - 5) check(!almost_empty, "R6", "almost_empty at 5", 64'(almost_empty), 0);
      if (i == DEPTH - 4) check(almost_empty, "R6", "almost_empty at 4", 64'(almost_empty), 1);
      pop_check(pat(i), exp_par(pat(i)), 0, 0, "R2");
    end
    check(empty, "R5", "empty after drain", 64'(empty), 1);
    @(negedge rd_clk);
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    check(rd_underflow, "R5", "underflow pulse", 64'(rd_underflow), 1);
    check(rd_data === pat(DEPTH - 1), "R5", "rd_data kept", rd_data, pat(DEPTH - 1));
    check(rd_count == 10'd517, "R5", "rd_count kept", 64'(rd_count), 517);
    @(negedge rd_clk);
    check(!rd_underflow, "R5", "underflow single cycle", 64'(rd_underflow), 0);
  endtask

  task automatic t_inject();
    logic [63:0] x, bad;
    x = 64'h0F1E_2D3C_4B5A_6978;
    bad = x ^ (64'd1 << 30) ^ (64'd1 << 62);
    push(x, 1, 0);
    push(x, 0, 1);
    push(x, 1, 1);
    settle();
    pop_check(x, exp_par(x), 1, 0, "R7");
    pop_check(bad, exp_par(x), 0, 1, "R8");
    pop_check(bad, exp_par(x), 0, 1, "R8");
  endtask

  task automatic t_reset_keep();
    logic [63:0] x;
    x = 64'h0F1E_2D3C_4B5A_6978 ^ (64'd1 << 30) ^ (64'd1 << 62);
    push(64'h1234, 0, 0);
    @(negedge wr_clk);
    rst_n = 0;
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    @(negedge rd_clk);
    check(rd_data === x && err_double === 1'b1 && err_single === 1'b0, "R10",
          "outputs kept in reset", rd_data, x);
    check(wr_count == 0 && rd_count == 0 && empty, "R10", "counts cleared",
          {wr_count, rd_count, empty}, 64'd1);
    rst_n = 1;
    settle();
    @(negedge rd_clk);
    check(rd_data === x && rd_parity === exp_par(64'h0F1E_2D3C_4B5A_6978), "R10",
          "outputs kept after reset", rd_data, x);
  endtask

  initial begin
    t_reset();
    t_order();
    t_fill_drain();
    t_inject();
    t_reset_keep();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule